// File: doc/BRIEF.md
# AHB Burst Master Transfer Generator

This block is the address-phase engine of an AHB-Lite master. A local controller hands it one burst command at a time: start address, burst code, beat size, direction and protection bits. A FIFO-side `data_avail` flag tells it whether data for the next beat exists. The engine then drives the transfer type, address and control lines of the bus, beat by beat.

The engine keeps its own burst state. It knows which beat it is on and how many beats the burst has. It holds the control that was captured when the burst started. It computes each following address from the burst pattern. When local data runs dry in the middle of a burst, it parks the bus in BUSY with the pending address and resumes with SEQ, so the burst is paused and never abandoned.

Commands that cannot be issued legally are consumed and flagged through `cmd_err`, and nothing reaches the bus. This covers an incrementing burst that would cross a 1 KB line, a size wider than the data bus, a misaligned start and the unsupported undefined-length code.

Top module: `ahb_burst_master`

## Requirements
- R1: The first beat of every burst is driven with transfer type NONSEQ (code 2). Every later beat, including one that follows a pause, is driven as SEQ (code 3).
- R2: Inside a burst, if `data_avail` is low at the edge that completes a beat or at a BUSY cycle, the next cycle shows BUSY (code 1) with the pending beat's address. Type IDLE (code 0) never appears before the last beat completes. BUSY lasts until `data_avail` is seen high, and the burst then resumes with SEQ.
- R3: For SINGLE (burst code 0) and incrementing bursts INCR4/INCR8/INCR16 (codes 3/5/7), beat k is at start + k·2^size.
- R4: For wrapping bursts WRAP4/WRAP8/WRAP16 (codes 2/4/6), addresses step by 2^size and wrap inside the block of beats·2^size bytes aligned to that block size.
- R5: `hwrite`, `hsize`, `hburst` and `hprot` take the command values at the NONSEQ beat and stay unchanged through the burst's BUSY and SEQ cycles.
- R6: While `hready` is low, `htrans`, `haddr` and the control outputs hold their values, and no beat advances.
- R7: `cmd_ready` is high when the engine is idle, or when the last beat is being completed with `hready` high. An accepted command appears as NONSEQ in the next cycle, back to back with a finishing burst. After a last beat with no command accepted, the bus shows IDLE.
- R8: A fixed-length incrementing burst whose byte span would extend past a 1 KB boundary is rejected. A burst that ends exactly at the boundary, and any wrapping burst, are accepted.
- R9: A command is also rejected when its size exceeds log2 of the data-bus bytes, when its burst code is 1, or when its address is not aligned to 2^size.
- R10: A rejected command raises `cmd_err` for exactly one cycle, the cycle after acceptance, and the bus stays IDLE. After reset the bus shows IDLE, `cmd_err` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command is taken this cycle when valid |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_burst | input | 3 | Burst code |
| cmd_size | input | 3 | Beat size as log2 bytes |
| cmd_write | input | 1 | 1 = write burst |
| cmd_prot | input | 4 | Protection bits for the burst |
| cmd_err | output | 1 | One-cycle pulse: last taken command was rejected |
| data_avail | input | 1 | Local data exists for the next beat |
| hready | input | 1 | Bus ready; low extends the current phase |
| htrans | output | 2 | Transfer type |
| haddr | output | ADDR_W | Bus address |
| hburst | output | 3 | Burst code on the bus |
| hsize | output | 3 | Beat size on the bus |
| hwrite | output | 1 | Direction on the bus |
| hprot | output | 4 | Protection on the bus |

## Verification
Every bus output is a register. A command accepted at an edge therefore shows its NONSEQ on the next cycle. A low `data_avail` at a completing edge shows BUSY one cycle later. A low `hready` freezes the outputs that are seen after that edge. `cmd_err` rises one cycle after a rejected command is taken and falls the cycle after that. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each result is checked exactly one registered stage after its cause. Its beat index advances only on cycles it drove as ready with a real transfer shown.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_BUSY = 2'd1,
        TR_NSEQ = 2'd2,
        TR_SEQ  = 2'd3
    } trans_e;

    typedef struct packed {
        logic       wr;
        logic [2:0] size;
        logic [2:0] burst;
        logic [3:0] prot;
    } ctrl_t;

    localparam int BEAT_W = 5;

    // Number of beats carried by a burst code
    function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] b);
        case (b)
            3'd2, 3'd3: beats_of = BEAT_W'(4);
            3'd4, 3'd5: beats_of = BEAT_W'(8);
            3'd6, 3'd7: beats_of = BEAT_W'(16);
            default:    beats_of = BEAT_W'(1);
        endcase
    endfunction

    function automatic logic is_wrap(input logic [2:0] b);
        is_wrap = (b == 3'd2) || (b == 3'd4) || (b == 3'd6);
    endfunction

endpackage

// File: rtl/ahbm_cmd_check.sv
module ahbm_cmd_check
    import ahbm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BOUND_LOG2 = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        burst,
    input  logic [2:0]        size,
    output logic              ok
);
    localparam int MAX_SIZE = $clog2(DATA_W / 8);
    localparam int SPAN_W   = BOUND_LOG2 + 8;

    logic              size_ok, burst_ok, align_ok, crosses;
    logic [ADDR_W-1:0] lo_mask;
    logic [SPAN_W-1:0] span, end_off;

    always_comb begin
        size_ok  = (int'(size) <= MAX_SIZE);
        burst_ok = (burst != 3'd1);
        lo_mask  = (ADDR_W'(1) << size) - ADDR_W'(1);
        align_ok = ((addr & lo_mask) == '0);
        span     = SPAN_W'(beats_of(burst)) << size;
        end_off  = SPAN_W'(addr[BOUND_LOG2-1:0]) + span;
        crosses  = !is_wrap(burst) && (burst != 3'd0)
                   && (end_off > (SPAN_W'(1) << BOUND_LOG2));
        ok       = size_ok && burst_ok && align_ok && !crosses;
    end
endmodule

// File: rtl/ahbm_addr_gen.sv
module ahbm_addr_gen
    import ahbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [2:0]        burst,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc, wmask;

    always_comb begin
        inc   = addr + (ADDR_W'(1) << size);
        wmask = (ADDR_W'(beats_of(burst)) << size) - ADDR_W'(1);
        if (is_wrap(burst))
            nxt = (addr & ~wmask) | (inc & wmask);
        else
            nxt = inc;
    end
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
    import ahbm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_burst,
    input  logic [2:0]        cmd_size,
    input  logic              cmd_write,
    input  logic [3:0]        cmd_prot,
    output logic              cmd_err,
    input  logic              data_avail,
    input  logic              hready,
    output logic [1:0]        htrans,
    output logic [ADDR_W-1:0] haddr,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              hwrite,
    output logic [3:0]        hprot
);
    trans_e            tr_q;
    logic [ADDR_W-1:0] addr_q;
    ctrl_t             ctl_q;
    logic [BEAT_W-1:0] beat_q, len_q;
    logic              err_q;

    logic              cmd_ok;
    logic [ADDR_W-1:0] addr_nxt;
    logic              is_xfer, last_beat, take;
    trans_e            cont_tr;

    ahbm_cmd_check #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOUND_LOG2(BOUND_LOG2)
    ) u_check (
        .addr(cmd_addr), .burst(cmd_burst), .size(cmd_size), .ok(cmd_ok)
    );

    ahbm_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .addr(addr_q), .size(ctl_q.size), .burst(ctl_q.burst), .nxt(addr_nxt)
    );

    always_comb begin
        is_xfer   = (tr_q == TR_NSEQ) || (tr_q == TR_SEQ);
        last_beat = is_xfer && (beat_q == len_q - BEAT_W'(1));
        cmd_ready = hready && ((tr_q == TR_IDLE) || last_beat);
        take      = cmd_valid && cmd_ready;
        cont_tr   = data_avail ? TR_SEQ : TR_BUSY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q   <= TR_IDLE;
            addr_q <= '0;
            ctl_q  <= '0;
            beat_q <= '0;
            len_q  <= BEAT_W'(1);
            err_q  <= 1'b0;
        end else begin
            err_q <= take && !cmd_ok;
            if (hready) begin
                if (take && cmd_ok) begin
                    tr_q   <= TR_NSEQ;
                    addr_q <= cmd_addr;
                    ctl_q  <= '{wr: cmd_write, size: cmd_size,
                               burst: cmd_burst, prot: cmd_prot};
                    beat_q <= '0;
                    len_q  <= beats_of(cmd_burst);
                end else if (last_beat || tr_q == TR_IDLE) begin
                    tr_q <= TR_IDLE;
                end else if (is_xfer) begin
                    tr_q   <= cont_tr;
                    beat_q <= beat_q + BEAT_W'(1);
                    addr_q <= addr_nxt;
                end else begin
                    tr_q <= cont_tr;
                end
            end
        end
    end

    assign htrans  = tr_q;
    assign haddr   = addr_q;
    assign hburst  = ctl_q.burst;
    assign hsize   = ctl_q.size;
    assign hwrite  = ctl_q.wr;
    assign hprot   = ctl_q.prot;
    assign cmd_err = err_q;
endmodule

// File: rtl/ahbm_checker.sv
module ahbm_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              hready,
    input logic              cmd_err,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic [2:0]        hburst,
    input logic [2:0]        hsize,
    input logic              hwrite,
    input logic [3:0]        hprot
);
    AST_SEQ_NOT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'd3) |-> ($past(htrans) != 2'd0)); // R1

    AST_NO_IDLE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(htrans) == 2'd1) |-> (htrans != 2'd0)); // R2

    AST_RESUME_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        ($past(htrans) == 2'd1 && htrans == 2'd3) |-> $stable(haddr)); // R2

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
        (htrans == 2'd3 || htrans == 2'd1)
        |-> ($stable(hburst) && $stable(hsize) && $stable(hwrite) && $stable(hprot))); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(hready))
        |-> ($stable(htrans) && $stable(haddr) && $stable(hburst) && $stable(hsize)
             && $stable(hwrite) && $stable(hprot))); // R6

    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (htrans == 2'd0)); // R10
endmodule

bind ahb_burst_master ahbm_checker #(.ADDR_W(ADDR_W)) u_ahbm_chk (
    .clk(clk), .rst(rst), .hready(hready), .cmd_err(cmd_err), .htrans(htrans),
    .haddr(haddr), .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hprot(hprot)
);

// File: tb/tb_ahb_burst_master.sv
module tb_ahb_burst_master;
    logic        clk = 0, rst = 1;
    logic        cmd_valid = 0, cmd_ready, cmd_write = 0, cmd_err;
    logic [31:0] cmd_addr = 0, haddr;
    logic [2:0]  cmd_burst = 0, cmd_size = 0, hburst, hsize;
    logic [3:0]  cmd_prot = 0, hprot;
    logic        data_avail = 1, hready = 1, hwrite;
    logic [1:0]  htrans;
    int          checks = 0, fails = 0;

    ahb_burst_master dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_size(cmd_size),
        .cmd_write(cmd_write), .cmd_prot(cmd_prot), .cmd_err(cmd_err),
        .data_avail(data_avail), .hready(hready), .htrans(htrans), .haddr(haddr),
        .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hprot(hprot)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int blen(input logic [2:0] b);
        if (b == 2 || b == 3) return 4;
        if (b == 4 || b == 5) return 8;
        if (b == 6 || b == 7) return 16;
        return 1;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [2:0] b,
                                             input logic [2:0] s, input int k);
        int step = 1 << s;
        int blk  = blen(b) * step;
        logic [31:0] base;
        if (b == 2 || b == 4 || b == 6) begin
            base = a - (a % blk);
            return base + ((a - base + k * step) % blk);
        end
        return a + k * step;
    endfunction

    task automatic run_burst(input logic [31:0] a, input logic [2:0] b, input logic [2:0] s,
                             input logic w, input logic [3:0] p, input int gap, input int stall);
        int len = blen(b);
        int k = 0, busy = 0, guard = 0;
        bit stalled = 0, in_stall = 0, xfer;
        logic [1:0] st; logic [31:0] sa;
        string areq = (b == 2 || b == 4 || b == 6) ? "R4" : "R3";
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R7 ready when idle", cmd_ready, 1);
        cmd_valid = 1; cmd_addr = a; cmd_burst = b; cmd_size = s; cmd_write = w; cmd_prot = p;
        hready = 1; data_avail = 1;
        @(negedge clk);
        cmd_valid = 0;
        while (k < len && guard < 200) begin
            guard++;
            if (in_stall) begin
                chk(htrans == st && haddr == sa, "R6 hold on stall", haddr, sa);
                in_stall = 0;
            end
            xfer = htrans[1];
            if (xfer) begin
                chk(htrans == (k == 0 ? 2'd2 : 2'd3), "R1 beat type", htrans, (k == 0 ? 2 : 3));
                chk(haddr == exp_addr(a, b, s, k), areq, haddr, exp_addr(a, b, s, k));
                chk(hwrite == w && hsize == s && hburst == b && hprot == p, "R5 control",
                    {hwrite, hsize, hburst, hprot}, {w, s, b, p});
            end else if (htrans == 2'd1) begin
                busy++;
                chk(k > 0 && haddr == exp_addr(a, b, s, k), "R2 busy address", haddr, exp_addr(a, b, s, k));
            end else begin
                chk(0, "R2 idle inside burst", htrans, 1);
                k = len;
            end
            if (xfer && k == stall && !stalled) begin
                hready = 0; stalled = 1; in_stall = 1; st = htrans; sa = haddr;
            end else hready = 1;
            data_avail = !((xfer && k == gap) || (htrans == 2'd1 && busy < 2));
            if (xfer && hready) k++;
            @(negedge clk);
        end
        chk(htrans == 2'd0, "R7 idle after last beat", htrans, 0);
        chk(busy == (gap < len - 1 ? 2 : 0), "R2 busy count", busy, (gap < len - 1 ? 2 : 0));
        hready = 1; data_avail = 1;
    endtask

    task automatic try_cmd(input logic [31:0] a, input logic [2:0] b, input logic [2:0] s,
                           input bit good, input string req);
        @(negedge clk);
        cmd_valid = 1; cmd_addr = a; cmd_burst = b; cmd_size = s; cmd_write = 1; cmd_prot = 4'h3;
        @(negedge clk);
        cmd_valid = 0;
        if (good) begin
            chk(htrans == 2'd2 && cmd_err == 0, req, {htrans, cmd_err}, 3'b100);
            repeat (blen(b)) @(negedge clk);
            chk(htrans == 2'd0, req, htrans, 0);
        end else begin
            chk(cmd_err == 1 && htrans == 2'd0, {req, " reject"}, {htrans, cmd_err}, 3'b001);
            @(negedge clk);
            chk(cmd_err == 0, "R10 err one cycle", cmd_err, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [2:0] bl [7] = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        int idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(htrans == 0 && cmd_err == 0 && cmd_ready == 1, "R10 reset state",
            {htrans, cmd_err, cmd_ready}, 4'b0001);

        // Sweep: every burst code, size and direction, with a pause and a stall
        foreach (bl[i]) for (int s = 0; s < 3; s++) for (int w = 0; w < 2; w++) begin
            int len = blen(bl[i]);
            logic [31:0] a = 32'h2000 + (((idx * 5) % 16) << s);
            run_burst(a, bl[i], 3'(s), w[0], idx[3:0], idx % len, (idx + 1) % len);
            idx++;
        end

        // Back-to-back: second command taken on the first burst's last beat (R7)
        @(negedge clk);
        cmd_valid = 1; cmd_addr = 32'h3000; cmd_burst = 3; cmd_size = 2; cmd_write = 0; cmd_prot = 0;
        @(negedge clk);
        cmd_addr = 32'h4000; cmd_burst = 0; cmd_write = 1;
        for (int k = 0; k < 4; k++) begin
            chk(cmd_ready == (k == 3), "R7 ready only on last beat", cmd_ready, (k == 3));
            @(negedge clk);
        end
        cmd_valid = 0;
        chk(htrans == 2 && haddr == 32'h4000 && hwrite == 1 && hburst == 0,
            "R7 back-to-back NONSEQ", haddr, 32'h4000);
        @(negedge clk);
        chk(htrans == 0, "R7 idle after single", htrans, 0);

        // 1 KB boundary and legality (R8, R9)
        try_cmd(32'h3F8, 3, 2, 0, "R8 cross");
        try_cmd(32'h3F0, 3, 2, 1, "R8 end on boundary");
        try_cmd(32'h3F1, 7, 0, 0, "R8 INCR16 byte cross");
        try_cmd(32'h7F8, 2, 2, 1, "R8 wrap near boundary");
        try_cmd(32'h2000, 3, 3, 0, "R9 size too wide");
        try_cmd(32'h2000, 1, 2, 0, "R9 burst code 1");
        try_cmd(32'h2002, 0, 2, 0, "R9 misaligned");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule